// File: doc/BRIEF.md
# Tracking Soft-Start Reference Ramp

This block produces the digital voltage reference that a point-of-load regulator's control loop follows while the output is switched on and off. The reference is a code in steps of 6.25 mV, where code 0 is 0 V. On enable it climbs from its present value toward the requested setpoint. On disable it falls back to zero.

Both slopes are paced by the synchronized switching-cycle tick rather than by the local clock. Every converter that shares one switching clock therefore ramps at the same volts per millisecond, and the outputs track one another. At a 500 kHz tick the rise is 0.1 V/ms and the fall is 0.5 V/ms. A fractional phase accumulator keeps both average rates exact.

A fault request bypasses the controlled ramp and forces the reference to zero at once. A ramping flag tells the power-good logic to ignore the output window while the reference moves. A state code reports where the sequencer stands.

Top module: `track_ramp_seq`

## Requirements
- R1: After reset, ref_o is 0, state_o is 0 (off) and ramping_o is low. The state codes are: 0 off, 1 ramping up, 2 regulating, 3 ramping down, 4 fault off.
- R2: From off with en_i high and no fault, state_o becomes 1 at the next clock edge, with no tick required.
- R3: On each entry to state 1, the target is latched from setpoint_i, clamped to the range 80..880 (0.5 V to 5.5 V). A setpoint change after that entry has no effect on the reference until the next entry.
- R4: In state 1, the m-th one-code step toward the target falls on tick number ceil((125m-121)/4) after entry. This is one code per 31.25 ticks on average, and the first step falls on the first tick.
- R5: In state 3, the m-th one-code step down falls on tick number ceil((25m-21)/4) after entry. This is one code per 6.25 ticks on average.
- R6: ref_o changes only on a clock where tick_i is high, and then by at most one code, unless a fault forces it to zero.
- R7: ramping_o is high exactly in states 1 and 3. The first tick after ref_o equals the target moves state 1 to state 2, so the flag stays high for one tick after the reference arrives.
- R8: en_i low in state 1 or 2 gives state 3 at the next edge. When ref_o is 0 in state 3, the next tick gives state 0.
- R9: en_i high in state 3 gives state 1 at the next edge with ref_o unchanged. The ramp then continues upward from that value without a jump.
- R10: fault_i high gives state 4 with ref_o 0 at the next edge, from any state. The block stays in state 4 while fault_i is high and goes to state 0 on the first edge after fault_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable, active high; the board pulls the pin high when left open |
| setpoint_i | input | 10 | Final output voltage code, 6.25 mV per code |
| tick_i | input | 1 | One-clock pulse per synchronized switching cycle |
| fault_i | input | 1 | Shutdown request from protection logic |
| ref_o | output | 10 | Reference code for the control loop |
| ramping_o | output | 1 | High while the reference is ramping |
| state_o | output | 3 | Sequencer state code |

## Verification
The assertions assume that tick_i is a clean synchronous pulse, high for at most one clock per switching cycle when it is not held high on purpose. They also assume that en_i, setpoint_i and fault_i change only between clock edges. The stimulus drives every input on the falling edge. It holds tick_i high for long stretches so that the ramp timing can be counted in clocks, and it gates tick_i low for one window only, to show that the reference freezes without ticks. Faults are raised in the middle of a ramp, and enable is reversed partway through a descent.

// File: rtl/track_ramp_pkg.sv
package track_ramp_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_UP    = 3'd1,
        ST_REG   = 3'd2,
        ST_DOWN  = 3'd3,
        ST_FAULT = 3'd4
    } ramp_state_e;

endpackage

// File: rtl/ramp_pacer.sv
module ramp_pacer #(
    parameter int PERIOD = 125,
    parameter int INC    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic adv_i,
    output logic step_o
);
    localparam int ACC_W = $clog2(PERIOD + INC + 1);
    localparam logic [ACC_W-1:0] PER_C  = ACC_W'(PERIOD);
    localparam logic [ACC_W-1:0] INC_C  = ACC_W'(INC);
    localparam logic [ACC_W-1:0] PRE_C  = ACC_W'(PERIOD - INC);

    logic [ACC_W-1:0] acc_d, acc_q, sum;

    always_comb begin
        sum    = acc_q + INC_C;
        step_o = adv_i && (sum >= PER_C);
        acc_d  = acc_q;
        if (load_i)
            acc_d = PRE_C;
        else if (adv_i)
            acc_d = (sum >= PER_C) ? (sum - PER_C) : sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/target_clamp.sv
module target_clamp #(
    parameter int W   = 10,
    parameter int MIN = 80,
    parameter int MAX = 880
) (
    input  logic [W-1:0] code_i,
    output logic [W-1:0] code_o
);
    localparam logic [W-1:0] MIN_C = W'(MIN);
    localparam logic [W-1:0] MAX_C = W'(MAX);

    always_comb begin
        if (code_i < MIN_C)      code_o = MIN_C;
        else if (code_i > MAX_C) code_o = MAX_C;
        else                     code_o = code_i;
    end
endmodule

// File: rtl/track_ramp_seq.sv
module track_ramp_seq
    import track_ramp_pkg::*;
#(
    parameter int CODE_W      = 10,
    parameter int SET_MIN     = 80,
    parameter int SET_MAX     = 880,
    parameter int PHASE_INC   = 4,
    parameter int RISE_PERIOD = 125,
    parameter int FALL_PERIOD = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [CODE_W-1:0] setpoint_i,
    input  logic              tick_i,
    input  logic              fault_i,
    output logic [CODE_W-1:0] ref_o,
    output logic              ramping_o,
    output logic [2:0]        state_o
);
    typedef struct packed {
        ramp_state_e       state;
        logic [CODE_W-1:0] refc;
        logic [CODE_W-1:0] target;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic [CODE_W-1:0] clamped;
    logic rise_load, fall_load, rise_step, fall_step;
    logic rise_adv, fall_adv;

    target_clamp #(.W(CODE_W), .MIN(SET_MIN), .MAX(SET_MAX)) i_clamp (
        .code_i (setpoint_i),
        .code_o (clamped)
    );

    assign rise_adv = tick_i && (cur_q.state == ST_UP);
    assign fall_adv = tick_i && (cur_q.state == ST_DOWN);

    ramp_pacer #(.PERIOD(RISE_PERIOD), .INC(PHASE_INC)) i_rise (
        .clk(clk), .rst_n(rst_n), .load_i(rise_load), .adv_i(rise_adv), .step_o(rise_step)
    );

    ramp_pacer #(.PERIOD(FALL_PERIOD), .INC(PHASE_INC)) i_fall (
        .clk(clk), .rst_n(rst_n), .load_i(fall_load), .adv_i(fall_adv), .step_o(fall_step)
    );

    always_comb begin
        nxt_d     = cur_q;
        rise_load = 1'b0;
        fall_load = 1'b0;
        case (cur_q.state)
            ST_OFF: begin
                nxt_d.refc = '0;
                if (en_i) begin
                    nxt_d.state  = ST_UP;
                    nxt_d.target = clamped;
                    rise_load    = 1'b1;
                end
            end
            ST_UP: begin
                if (!en_i) begin
                    nxt_d.state = ST_DOWN;
                    fall_load   = 1'b1;
                end else if (tick_i) begin
                    if (cur_q.refc == cur_q.target)
                        nxt_d.state = ST_REG;
                    else if (rise_step)
                        nxt_d.refc = (cur_q.refc < cur_q.target) ? cur_q.refc + 1'b1
                                                                 : cur_q.refc - 1'b1;
                end
            end
            ST_REG: begin
                if (!en_i) begin
                    nxt_d.state = ST_DOWN;
                    fall_load   = 1'b1;
                end
            end
            ST_DOWN: begin
                if (en_i) begin
                    nxt_d.state  = ST_UP;
                    nxt_d.target = clamped;
                    rise_load    = 1'b1;
                end else if (tick_i) begin
                    if (cur_q.refc == '0)
                        nxt_d.state = ST_OFF;
                    else if (fall_step)
                        nxt_d.refc = cur_q.refc - 1'b1;
                end
            end
            ST_FAULT: begin
                nxt_d.refc = '0;
                if (!fault_i) nxt_d.state = ST_OFF;
            end
            default: begin
                nxt_d.state = ST_OFF;
                nxt_d.refc  = '0;
            end
        endcase
        if (fault_i) begin
            nxt_d.state = ST_FAULT;
            nxt_d.refc  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state  <= ST_OFF;
            cur_q.refc   <= '0;
            cur_q.target <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ref_o     = cur_q.refc;
    assign state_o   = cur_q.state;
    assign ramping_o = (cur_q.state == ST_UP) || (cur_q.state == ST_DOWN);
endmodule

// File: rtl/track_ramp_chk.sv
module track_ramp_chk #(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              tick_i,
    input logic              fault_i,
    input logic [CODE_W-1:0] ref_o,
    input logic              ramping_o,
    input logic [2:0]        state_o
);
    // R2
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && en_i && !fault_i) |=> state_o == 3'd1);

    // R6
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !fault_i) |=> $stable(ref_o));

    // R6
    p_unit_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !fault_i) |=>
            (ref_o == $past(ref_o) || ref_o == $past(ref_o) + 1'b1 || ref_o + 1'b1 == $past(ref_o)));

    // R7
    p_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ramping_o == (state_o == 3'd1 || state_o == 3'd3));

    // R8
    p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd1 || state_o == 3'd2) && !en_i && !fault_i) |=> state_o == 3'd3);

    // R9
    p_reverse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && en_i && !fault_i) |=> (state_o == 3'd1 && $stable(ref_o)));

    // R10
    p_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> (state_o == 3'd4 && ref_o == '0));

    // R1
    p_off_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0) |-> ref_o == '0);
endmodule

bind track_ramp_seq track_ramp_chk #(.CODE_W(CODE_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick_i), .fault_i(fault_i),
    .ref_o(ref_o), .ramping_o(ramping_o), .state_o(state_o)
);

// File: tb/test_track_ramp_seq.sv
module test_track_ramp_seq;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic [9:0] sp;
    logic       tick;
    logic       fault;
    logic [9:0] ref_c;
    logic       ramping;
    logic [2:0] state;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    track_ramp_seq i_track_ramp_seq (
        .clk(clk), .rst_n(rst_n), .en_i(en), .setpoint_i(sp), .tick_i(tick),
        .fault_i(fault), .ref_o(ref_c), .ramping_o(ramping), .state_o(state)
    );

    // setpoint, clamped target, ticks to reach target, ticks to reach zero
    localparam int NV = 5;
    localparam int VEC [NV][4] = '{
        '{ 80,  80,  2470,  495},
        '{ 40,  80,  2470,  495},
        '{100, 100,  3095,  620},
        '{900, 880, 27470, 5495},
        '{  0,  80,  2470,  495}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ref(input int target, input int limit, output int cnt);
        cnt = 0;
        do begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
        end while (ref_c != target && cnt < limit);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int cnt;
        int r0;
        rst_n = 1'b0; en = 1'b0; sp = '0; tick = 1'b0; fault = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ref in reset", ref_c, 0);
        check("R1 state in reset", state, 0);
        check("R1 ramping in reset", ramping, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 state after reset", state, 0);
        tick = 1'b1;

        for (int i = 0; i < NV; i++) begin
            sp = VEC[i][0];
            en = 1'b1;
            @(negedge clk);
            check("R2 enter ramp up", state, 1);
            wait_ref(VEC[i][1], 40000, cnt);
            check("R4 rise ticks", cnt, VEC[i][2]);
            check("R3 clamped target", ref_c, VEC[i][1]);
            check("R7 flag held at arrival", ramping, 1);
            @(negedge clk);
            check("R7 regulate after extra tick", state, 2);
            check("R7 flag cleared", ramping, 0);
            en = 1'b0;
            @(negedge clk);
            check("R8 enter ramp down", state, 3);
            wait_ref(0, 10000, cnt);
            check("R5 fall ticks", cnt, VEC[i][3]);
            check("R8 still ramping down at zero", state, 3);
            @(negedge clk);
            check("R8 off after zero", state, 0);
        end

        // R3: setpoint change while regulating is ignored
        sp = 10'd100;
        en = 1'b1;
        @(negedge clk);
        wait_ref(100, 40000, cnt);
        @(negedge clk);
        sp = 10'd200;
        repeat (50) @(negedge clk);
        check("R3 ref ignores new setpoint", ref_c, 100);
        check("R3 state stays regulate", state, 2);

        // R9: reversal during ramp down
        en = 1'b0;
        repeat (200) @(negedge clk);
        check("R5 partial descent", ref_c, 68);
        r0 = ref_c;
        en = 1'b1;
        @(negedge clk);
        check("R9 state after re-enable", state, 1);
        check("R9 no jump", ref_c, r0);
        @(negedge clk);
        check("R9 continues upward", ref_c, r0 + 1);

        // R6: no tick, no movement
        tick = 1'b0;
        repeat (20) @(negedge clk);
        check("R6 frozen without tick", ref_c, r0 + 1);
        check("R6 state kept", state, 1);
        tick = 1'b1;

        // R10: fault bypasses the ramp
        repeat (5) @(negedge clk);
        fault = 1'b1;
        @(negedge clk);
        check("R10 fault state", state, 4);
        check("R10 fault ref zero", ref_c, 0);
        check("R10 fault ramping low", ramping, 0);
        repeat (10) @(negedge clk);
        check("R10 fault held", state, 4);
        fault = 1'b0;
        @(negedge clk);
        check("R10 off after release", state, 0);
        @(negedge clk);
        check("R2 restart after fault", state, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule